// File: doc/BRIEF.md
# Flash Bus Interface Front-End

This block sits between the asynchronous host pins of a byte/word switchable flash memory and the synchronous core logic that runs on a fast system clock. Every control pin is brought into the clock domain through a synchronizer, and the block derives from those pins a device-select flag, a per-lane drive mask with read data for the bidirectional data bus, and single-cycle write events that carry a decoded address and the data word. A write-strobe falling edge produces a separate page-buffer address event. A write-strobe rising edge produces the command/data write event.

Both chip enables must be low for the device to be selected. Selection therefore starts at the later falling enable and ends at the first rising one. Chip enable takes priority over output enable, and output enable takes priority over write enable. In byte mode, address bit 0 selects a byte lane. In word mode, that bit is ignored. A low level on the reset pin holds the core in reset and blocks all access. After the reset pin is released, the interface waits a parameterised number of recovery cycles before it accepts access again.

Top module: `flash_bus_frontend`

## Requirements
- R1: `dev_sel` is 1 only while both synchronized chip enables are low and `if_ready` is 1. It returns to 0 once either enable goes high.
- R2: `dq_drv` is nonzero only while `dev_sel` is 1 and `oe_n` is low. `dq_drv` bit 0 enables the low lane (bits 7..0) and bit 1 enables the high lane (bits 15..8).
- R3: A rising edge of `we_n` with the device selected, `oe_n` high and the interface ready gives exactly one `wr_evt` pulse. With that pulse, `wr_data` holds `dq_in`, `wr_blk` holds addr[20:16], `wr_row` holds addr[15:6] and `wr_col` holds addr[5:1].
- R4: A `we_n` edge that occurs while `oe_n` is low produces neither `wr_evt` nor `pb_evt`.
- R5: A falling edge of `we_n` under the conditions of R3 gives one `pb_evt` pulse, with `pb_row` = addr[15:6], `pb_col` = addr[5:1] and `pb_hi_byte` as in R6. A rising edge of `we_n` produces no `pb_evt`.
- R6: In byte mode (`byte_n` low), `wr_hi_byte`/`pb_hi_byte` equal addr[0] and `wr_byte_mode` is 1. A read drives mask 01, and the low lane carries arr_rdata[15:8] when addr[0] is 1 and arr_rdata[7:0] when it is 0. In word mode, addr[0] is ignored, `wr_hi_byte` is 0, and a read drives mask 11 with the full `arr_rdata`.
- R7: While `stat_mode` is 1, a read drives mask 01 with `stat_rdata` on the low lane, in either mode. The high lane stays floated.
- R8: While the reset pin is low, `core_rst` is 1, and `if_ready`, `dev_sel`, `dq_drv`, `wr_evt` and `pb_evt` are all 0. A write whose falling edge came before the reset produces no `wr_evt`.
- R9: After `core_rst` falls, `if_ready` rises after exactly REC_CYC cycles. Writes during this recovery window produce no events.
- R10: `wr_evt` and `pb_evt` never stay high for two consecutive cycles and are never high together.
- R11: Write strobes that occur while the device is deselected produce no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on reset of the interface flops, active low |
| ce0_n | input | 1 | Chip enable 0, active low, asynchronous |
| ce1_n | input | 1 | Chip enable 1, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| rp_n | input | 1 | Reset / power-down pin, active low, asynchronous |
| byte_n | input | 1 | Low selects byte mode, high selects word mode |
| addr | input | ADDR_W | Host address |
| dq_in | input | DATA_W | Data bus input side |
| arr_rdata | input | DATA_W | Array/buffer read data from the core |
| stat_mode | input | 1 | Core is in status read mode |
| stat_rdata | input | DATA_W/2 | Status byte from the core |
| dev_sel | output | 1 | Device selected and ready |
| dq_drv | output | 2 | Per-lane bus drive mask |
| dq_out | output | DATA_W | Data bus output side |
| wr_evt | output | 1 | Single-cycle write event |
| wr_blk | output | BLK_W | Erase block of the write |
| wr_row | output | ROW_W | Row of the write |
| wr_col | output | COL_W | Column group of the write |
| wr_hi_byte | output | 1 | Write targets the high byte (byte mode) |
| wr_byte_mode | output | 1 | Write was made in byte mode |
| wr_data | output | DATA_W | Latched command or data |
| pb_evt | output | 1 | Single-cycle page-buffer address event |
| pb_row | output | ROW_W | Row captured on the strobe fall |
| pb_col | output | COL_W | Column group captured on the strobe fall |
| pb_hi_byte | output | 1 | High byte flag captured on the strobe fall |
| core_rst | output | 1 | Reset request to the core |
| if_ready | output | 1 | Interface accepts accesses |

## Verification
The properties assume that each pin level lasts longer than the synchronizer depth plus one cycle. They also assume that the address and data are stable from before a strobe falls until several cycles after it rises, and that `byte_n` changes only while no access is in progress. The bench drives every pin on the falling clock edge and holds each level for at least two synchronizer depths. It sets the address and data before it lowers a strobe and keeps them until after the matching event has been sampled. Mode pins change only between accesses, followed by a settling gap.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

   localparam int PIN_CE0  = 0;
   localparam int PIN_CE1  = 1;
   localparam int PIN_OE   = 2;
   localparam int PIN_WE   = 3;
   localparam int PIN_RP   = 4;
   localparam int PIN_BYTE = 5;
   localparam int NPIN     = 6;

   // idle pin levels: strobes/enables high, reset pin low (held in reset), word mode
   localparam logic [NPIN-1:0] PIN_IDLE = 6'b101111;

   typedef enum logic [1:0] {
      DRV_NONE = 2'b00,
      DRV_LOW  = 2'b01,
      DRV_BOTH = 2'b11
   } drv_e;

endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("flash_fe_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("flash_fe_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            chain[s] <= RST_VAL;
         end else if (s == 0) begin
            chain[s] <= d_async;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/flash_fe_rst_ctl.sv
module flash_fe_rst_ctl #(
   parameter int REC_CYC = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rp_s,
   output logic core_rst,
   output logic rdy
);
   if (REC_CYC < 0) begin : g_bad_rec
      $error("flash_fe_rst_ctl: REC_CYC must not be negative");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) core_rst <= 1'b1;
      else         core_rst <= ~rp_s;
   end

   if (REC_CYC == 0) begin : g_no_wait
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) rdy <= 1'b0;
         else         rdy <= rp_s;
      end
   end else begin : g_wait
      localparam int CW = $clog2(REC_CYC + 1) + 1;
      localparam logic [CW-1:0] LIM = CW'(REC_CYC);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            cnt <= '0;
            rdy <= 1'b0;
         end else if (!rp_s) begin
            cnt <= '0;
            rdy <= 1'b0;
         end else begin
            if (cnt != LIM) cnt <= cnt + 1'b1;
            rdy <= (cnt == LIM);
         end
      end
   end
endmodule

// File: rtl/flash_fe_addr_dec.sv
module flash_fe_addr_dec #(
   parameter int ADDR_W = 21,
   parameter int BLK_W = 5,
   parameter int ROW_W = 10,
   parameter int COL_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              byte_mode,
   output logic [BLK_W-1:0]  blk,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic              hi_byte
);
   localparam int COL_LSB = 1;
   localparam int ROW_LSB = COL_LSB + COL_W;
   localparam int BLK_LSB = ROW_LSB + ROW_W;

   if (ADDR_W != BLK_LSB + BLK_W) begin : g_bad_split
      $error("flash_fe_addr_dec: ADDR_W must equal 1 + COL_W + ROW_W + BLK_W");
   end

   always_comb begin
      blk     = addr[BLK_LSB +: BLK_W];
      row     = addr[ROW_LSB +: ROW_W];
      col     = addr[COL_LSB +: COL_W];
      hi_byte = byte_mode & addr[0];
   end
endmodule

// File: rtl/flash_fe_rd_lane.sv
module flash_fe_rd_lane
   import flash_fe_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              rd_en,
   input  logic              byte_mode,
   input  logic              a0,
   input  logic              stat_mode,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [DATA_W/2-1:0] stat_rdata,
   output logic [DATA_W-1:0] dq_out,
   output logic [1:0]        dq_drv
);
   localparam int LANE = DATA_W / 2;

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_w
      $error("flash_fe_rd_lane: DATA_W must be even");
   end

   logic [DATA_W-1:0] nxt_data;
   drv_e              nxt_drv;

   always_comb begin
      nxt_data = arr_rdata;
      nxt_drv  = DRV_BOTH;
      if (stat_mode) begin
         nxt_data = {{LANE{1'b0}}, stat_rdata};
         nxt_drv  = DRV_LOW;
      end else if (byte_mode) begin
         nxt_data = {{LANE{1'b0}}, (a0 ? arr_rdata[DATA_W-1:LANE] : arr_rdata[LANE-1:0])};
         nxt_drv  = DRV_LOW;
      end
      if (!rd_en) begin
         nxt_drv = DRV_NONE;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         dq_out <= '0;
         dq_drv <= DRV_NONE;
      end else begin
         dq_out <= nxt_data;
         dq_drv <= nxt_drv;
      end
   end
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
   import flash_fe_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16,
   parameter int BLK_W = 5,
   parameter int ROW_W = 10,
   parameter int COL_W = 5,
   parameter int SYNC_STAGES = 2,
   parameter int REC_CYC = 16
) (
   input  logic                clk,
   input  logic                arst_n,
   input  logic                ce0_n,
   input  logic                ce1_n,
   input  logic                oe_n,
   input  logic                we_n,
   input  logic                rp_n,
   input  logic                byte_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   dq_in,
   input  logic [DATA_W-1:0]   arr_rdata,
   input  logic                stat_mode,
   input  logic [DATA_W/2-1:0] stat_rdata,
   output logic                dev_sel,
   output logic [1:0]          dq_drv,
   output logic [DATA_W-1:0]   dq_out,
   output logic                wr_evt,
   output logic [BLK_W-1:0]    wr_blk,
   output logic [ROW_W-1:0]    wr_row,
   output logic [COL_W-1:0]    wr_col,
   output logic                wr_hi_byte,
   output logic                wr_byte_mode,
   output logic [DATA_W-1:0]   wr_data,
   output logic                pb_evt,
   output logic [ROW_W-1:0]    pb_row,
   output logic [COL_W-1:0]    pb_col,
   output logic                pb_hi_byte,
   output logic                core_rst,
   output logic                if_ready
);
   // synchronize all control pins
   logic [NPIN-1:0] pin_raw, pin_s;
   assign pin_raw = {byte_n, rp_n, we_n, oe_n, ce1_n, ce0_n};

   flash_fe_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d_async(pin_raw),
      .q_sync (pin_s)
   );

   logic ce0_s, ce1_s, oe_s, we_s, rp_s, byte_mode;
   assign ce0_s     = pin_s[PIN_CE0];
   assign ce1_s     = pin_s[PIN_CE1];
   assign oe_s      = pin_s[PIN_OE];
   assign we_s      = pin_s[PIN_WE];
   assign rp_s      = pin_s[PIN_RP];
   assign byte_mode = ~pin_s[PIN_BYTE];

   // reset pin and recovery window
   logic rdy;
   flash_fe_rst_ctl #(.REC_CYC(REC_CYC)) u_rst (
      .clk     (clk),
      .arst_n  (arst_n),
      .rp_s    (rp_s),
      .core_rst(core_rst),
      .rdy     (rdy)
   );
   assign if_ready = rdy;

   // selection and priority: enables gate everything, output enable blocks writes
   logic sel_s, acc, wr_ok, rd_ok;
   assign sel_s = ~ce0_s & ~ce1_s;
   assign acc   = sel_s & rdy & rp_s;
   assign rd_ok = acc & ~oe_s;
   assign wr_ok = acc & oe_s;

   // write strobe edges
   logic we_d, we_rise, we_fall;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) we_d <= 1'b1;
      else         we_d <= we_s;
   end
   assign we_rise = we_s & ~we_d;
   assign we_fall = ~we_s & we_d;

   // address decode
   logic [BLK_W-1:0] dec_blk;
   logic [ROW_W-1:0] dec_row;
   logic [COL_W-1:0] dec_col;
   logic             dec_hi;

   flash_fe_addr_dec #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
      .addr     (addr),
      .byte_mode(byte_mode),
      .blk      (dec_blk),
      .row      (dec_row),
      .col      (dec_col),
      .hi_byte  (dec_hi)
   );

   logic wr_fire, pb_fire;
   assign wr_fire = we_rise & wr_ok;
   assign pb_fire = we_fall & wr_ok;

   // write event on rising strobe
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         wr_evt       <= 1'b0;
         wr_blk       <= '0;
         wr_row       <= '0;
         wr_col       <= '0;
         wr_hi_byte   <= 1'b0;
         wr_byte_mode <= 1'b0;
         wr_data      <= '0;
      end else begin
         wr_evt <= wr_fire;
         if (wr_fire) begin
            wr_blk       <= dec_blk;
            wr_row       <= dec_row;
            wr_col       <= dec_col;
            wr_hi_byte   <= dec_hi;
            wr_byte_mode <= byte_mode;
            wr_data      <= dq_in;
         end
      end
   end

   // page-buffer address event on falling strobe
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         pb_evt     <= 1'b0;
         pb_row     <= '0;
         pb_col     <= '0;
         pb_hi_byte <= 1'b0;
      end else begin
         pb_evt <= pb_fire;
         if (pb_fire) begin
            pb_row     <= dec_row;
            pb_col     <= dec_col;
            pb_hi_byte <= dec_hi;
         end
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) dev_sel <= 1'b0;
      else         dev_sel <= acc;
   end

   // read path
   flash_fe_rd_lane #(.DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .arst_n    (arst_n),
      .rd_en     (rd_ok),
      .byte_mode (byte_mode),
      .a0        (addr[0]),
      .stat_mode (stat_mode),
      .arr_rdata (arr_rdata),
      .stat_rdata(stat_rdata),
      .dq_out    (dq_out),
      .dq_drv    (dq_drv)
   );
endmodule

// File: rtl/flash_fe_chk.sv
module flash_fe_chk #(
   parameter int REC_CYC = 16
) (
   input logic       clk,
   input logic       arst_n,
   input logic       dev_sel,
   input logic [1:0] dq_drv,
   input logic       wr_evt,
   input logic       pb_evt,
   input logic       core_rst,
   input logic       if_ready
);
   logic [15:0] since_rst;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                 since_rst <= '0;
      else if (core_rst)           since_rst <= '0;
      else if (since_rst != 16'hFFFF) since_rst <= since_rst + 16'd1;
   end

   a_r1_sel_needs_ready: assert property (@(posedge clk) disable iff (!arst_n)
      dev_sel |-> if_ready);
   a_r2_drive_needs_sel: assert property (@(posedge clk) disable iff (!arst_n)
      (dq_drv != 2'b00) |-> dev_sel);
   a_r4_no_write_while_driving: assert property (@(posedge clk) disable iff (!arst_n)
      (wr_evt || pb_evt) |-> (dq_drv == 2'b00));
   a_r6_mask_legal: assert property (@(posedge clk) disable iff (!arst_n)
      dq_drv != 2'b10);
   a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!arst_n)
      core_rst |-> (!if_ready && !dev_sel && !wr_evt && !pb_evt && dq_drv == 2'b00));
   a_r9_recovery_len: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(if_ready) |-> (since_rst == 16'(REC_CYC)));
   a_r10_wr_single: assert property (@(posedge clk) disable iff (!arst_n)
      wr_evt |=> !wr_evt);
   a_r10_pb_single: assert property (@(posedge clk) disable iff (!arst_n)
      pb_evt |=> !pb_evt);
   a_r10_not_both: assert property (@(posedge clk) disable iff (!arst_n)
      !(wr_evt && pb_evt));
   a_r11_write_needs_sel: assert property (@(posedge clk) disable iff (!arst_n)
      (wr_evt || pb_evt) |-> dev_sel);
endmodule

bind flash_bus_frontend flash_fe_chk #(.REC_CYC(REC_CYC)) u_chk (
   .clk     (clk),
   .arst_n  (arst_n),
   .dev_sel (dev_sel),
   .dq_drv  (dq_drv),
   .wr_evt  (wr_evt),
   .pb_evt  (pb_evt),
   .core_rst(core_rst),
   .if_ready(if_ready)
);

// File: tb/flash_bus_frontend_tb.sv
module flash_bus_frontend_tb;
   localparam int REC = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic arst_n = 1'b0;
   logic ce0_n = 1, ce1_n = 1, oe_n = 1, we_n = 1, rp_n = 0, byte_n = 1;
   logic [20:0] addr = '0;
   logic [15:0] dq_in = '0;
   logic stat_mode = 0;
   logic [15:0] arr_rdata;
   logic [7:0]  stat_rdata;
   assign arr_rdata  = addr[15:0] ^ 16'hA5C3;
   assign stat_rdata = 8'h9C;

   logic dev_sel, wr_evt, pb_evt, core_rst, if_ready, wr_hi_byte, wr_byte_mode, pb_hi_byte;
   logic [1:0] dq_drv;
   logic [15:0] dq_out, wr_data;
   logic [4:0] wr_blk, wr_col, pb_col;
   logic [9:0] wr_row, pb_row;

   flash_bus_frontend #(.REC_CYC(REC)) u_dut (
      .clk(clk), .arst_n(arst_n), .ce0_n(ce0_n), .ce1_n(ce1_n), .oe_n(oe_n), .we_n(we_n),
      .rp_n(rp_n), .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .arr_rdata(arr_rdata),
      .stat_mode(stat_mode), .stat_rdata(stat_rdata), .dev_sel(dev_sel), .dq_drv(dq_drv),
      .dq_out(dq_out), .wr_evt(wr_evt), .wr_blk(wr_blk), .wr_row(wr_row), .wr_col(wr_col),
      .wr_hi_byte(wr_hi_byte), .wr_byte_mode(wr_byte_mode), .wr_data(wr_data),
      .pb_evt(pb_evt), .pb_row(pb_row), .pb_col(pb_col), .pb_hi_byte(pb_hi_byte),
      .core_rst(core_rst), .if_ready(if_ready));

   int total = 0, bad = 0;
   int wr_cnt = 0, pb_cnt = 0, dbl = 0;
   logic prev_wr = 0, prev_pb = 0;
   bit finished = 0;

   // event monitor, sampled on falling edges
   always @(negedge clk) begin
      if (wr_evt) wr_cnt++;
      if (pb_evt) pb_cnt++;
      if ((wr_evt && prev_wr) || (pb_evt && prev_pb) || (wr_evt && pb_evt)) dbl++;
      prev_wr = wr_evt;
      prev_pb = pb_evt;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe_fall(input logic [20:0] a, input logic [15:0] d);
      cyc(1); addr = a; dq_in = d; cyc(2); we_n = 0; cyc(6);
   endtask

   task automatic strobe_rise();
      we_n = 1; cyc(6);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      int w0, p0, n;
      logic [20:0] a;
      logic [15:0] d;
      cyc(3);
      // reset state
      chk("R8 core_rst in reset", core_rst, 1);
      chk("R8 ready in reset", if_ready, 0);
      chk("R2 no drive in reset", dq_drv, 0);
      arst_n = 1; cyc(4);
      chk("R8 core_rst while rp low", core_rst, 1);
      // R9 recovery length
      rp_n = 1;
      n = 0;
      for (int k = 0; k < 200 && !if_ready; k++) begin
         @(negedge clk);
         if (!core_rst && !if_ready) n++;
      end
      chk("R9 recovery cycles", n, REC);
      chk("R9 ready after recovery", if_ready, 1);

      // R1 skewed enables
      ce0_n = 0; cyc(6);
      chk("R1 one enable low", dev_sel, 0);
      ce1_n = 0; cyc(6);
      chk("R1 both low", dev_sel, 1);
      ce0_n = 1; cyc(6);
      chk("R1 ce0 rose", dev_sel, 0);
      ce0_n = 0; cyc(6);
      ce1_n = 1; cyc(6);
      chk("R1 ce1 rose", dev_sel, 0);
      ce1_n = 0; cyc(6);

      // R3/R5 word-mode write sweep
      for (int i = 0; i < 10; i++) begin
         a = 21'(i * 32'h2F3A5 + 32'h1357);
         d = 16'(i * 32'h1111) ^ 16'h0F0F;
         w0 = wr_cnt; p0 = pb_cnt;
         strobe_fall(a, d);
         chk("R5 pb on fall", pb_cnt - p0, 1);
         chk("R5 no wr yet on fall", wr_cnt - w0, 0);
         chk("R5 pb row/col", {pb_row, pb_col}, {a[15:6], a[5:1]});
         strobe_rise();
         chk("R3 one wr", wr_cnt - w0, 1);
         chk("R5 no pb on rise", pb_cnt - p0, 1);
         chk("R3 fields", {wr_blk, wr_row, wr_col}, {a[20:16], a[15:6], a[5:1]});
         chk("R3 data", wr_data, d);
         chk("R6 word mode ignores a0", {wr_hi_byte, wr_byte_mode}, 2'b00);
      end

      // R6 byte-mode writes
      byte_n = 0; cyc(6);
      for (int i = 0; i < 4; i++) begin
         a = 21'(i * 32'h13579) | 21'(i & 1);
         a[0] = i[0];
         strobe_fall(a, 16'h00A0 + 16'(i));
         chk("R6 pb hi byte", pb_hi_byte, i[0]);
         strobe_rise();
         chk("R6 wr hi byte", wr_hi_byte, i[0]);
         chk("R6 wr byte mode", wr_byte_mode, 1);
      end
      byte_n = 1; cyc(6);

      // R4 write while output enable low
      oe_n = 0; cyc(6);
      w0 = wr_cnt; p0 = pb_cnt;
      strobe_fall(21'h0ABCD, 16'h1234); strobe_rise();
      chk("R4 oe low blocks wr", wr_cnt - w0, 0);
      chk("R4 oe low blocks pb", pb_cnt - p0, 0);
      oe_n = 1; cyc(6);

      // R11 write while deselected
      ce1_n = 1; cyc(6);
      w0 = wr_cnt; p0 = pb_cnt;
      strobe_fall(21'h1F00F, 16'h5555); strobe_rise();
      chk("R11 deselected no events", (wr_cnt - w0) + (pb_cnt - p0), 0);

      // R2/R6/R7 read sweep over select, oe, byte mode, status mode, a0
      for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
      for (int b = 0; b < 2; b++)
      for (int st = 0; st < 2; st++)
      for (int z = 0; z < 2; z++) begin
         logic en;
         logic [1:0] em;
         logic [15:0] ad;
         ce1_n = ~s[0]; oe_n = o[0]; byte_n = ~b[0]; stat_mode = st[0];
         addr = 21'h0B6D4 | 21'(z);
         cyc(6);
         ad = addr[15:0] ^ 16'hA5C3;
         en = s[0] && !o[0];
         em = !en ? 2'b00 : ((st != 0 || b != 0) ? 2'b01 : 2'b11);
         chk("R2 R6 R7 drive mask", dq_drv, em);
         if (en && st != 0)
            chk("R7 status on low lane", dq_out[7:0], stat_rdata);
         else if (en && b != 0)
            chk("R6 byte lane", dq_out[7:0], z != 0 ? ad[15:8] : ad[7:0]);
         else if (en)
            chk("R6 word read", dq_out, ad);
      end
      ce1_n = 0; oe_n = 1; byte_n = 1; stat_mode = 0; cyc(6);

      // R8 reset during a pending write, R9 access during recovery
      w0 = wr_cnt; p0 = pb_cnt;
      strobe_fall(21'h15A5A, 16'hBEEF);
      chk("R8 pending pb seen", pb_cnt - p0, 1);
      rp_n = 0; cyc(6);
      chk("R8 core_rst", core_rst, 1);
      chk("R8 deselected in reset", dev_sel, 0);
      strobe_rise();
      chk("R8 aborted write", wr_cnt - w0, 0);
      rp_n = 1; cyc(3);
      we_n = 0; cyc(2);
      chk("R9 not ready yet", if_ready, 0);
      we_n = 1; cyc(REC + 8);
      chk("R9 recovery ignores writes", (wr_cnt - w0) + (pb_cnt - p0 - 1), 0);
      chk("R9 ready again", if_ready, 1);
      strobe_fall(21'h0F0F1, 16'hCAFE); strobe_rise();
      chk("R3 write after recovery", wr_cnt - w0, 1);
      chk("R3 data after recovery", wr_data, 16'hCAFE);

      chk("R10 single pulses", dbl, 0);
      finish_run();
   end
endmodule